// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Resolver

This block sits ahead of a mantissa divider. Each cycle it looks at the class and sign of the dividend and of the divisor. A class is zero, normal, infinity or NaN, and a NaN also carries a signalling bit. From these the block decides whether the quotient is already known or whether the long division has to run. Division is not commutative, so the dividend and divisor are never swapped. Every invalid-operation cause raises its own flag, and a divide-by-zero flag is kept apart from them.

For each operand pair the block gives out five things: a one-hot path choice, the class of the result, the sign of the result, the exception flags, and the request that starts the divider. The path choice is forward the dividend, forward the divisor, build a default NaN, build a constant zero or infinity, or run the divider. Downstream logic uses the path to steer the operand mantissas or the divider output onto the result bus. A parameter picks whether the decision is registered once or passed through combinationally.

Top module: `fdsc_resolver`

## Requirements
- R1: Class codes are 00 zero, 01 normal, 10 infinity and 11 NaN. The result class is NaN when either operand is a NaN. If only one operand is a NaN, that operand is forwarded. If both are NaNs and exactly one of them has its signalling bit set, the signalling one is forwarded. If both are NaNs and their signalling bits match, the dividend is forwarded. In every NaN case the result sign is the sign of the forwarded operand.
- R2: The signalling-NaN flag is raised exactly when some NaN operand has its signalling bit set. A signalling bit on an operand that is not a NaN has no effect on any output.
- R3: Infinity divided by infinity selects the default-NaN path, with result class NaN and sign 0, and raises only the infinity-by-infinity flag.
- R4: Zero divided by zero selects the default-NaN path, with result class NaN and sign 0, and raises only the zero-by-zero flag.
- R5: Infinity divided by a normal number or by zero forwards the dividend. The result class is infinity, the sign is the dividend's sign, and no flag is raised.
- R6: Zero divided by a normal number or by infinity forwards the dividend. The result class is zero, the sign is the dividend's sign, and no flag is raised.
- R7: A normal number divided by infinity selects the constant path with class zero. A normal number divided by zero selects the constant path with class infinity and raises the divide-by-zero flag. In both cases the sign is the XOR of the two operand signs.
- R8: A normal number divided by a normal number sets the divider-request bit. The result class is normal, the sign is the XOR of the operand signs, and no flag is raised.
- R9: The path output is 5 bits. Bit 0 forwards the dividend, bit 1 forwards the divisor, bit 2 builds the default NaN, bit 3 builds the constant, and bit 4 requests the divider. Exactly one bit is set for every input combination, and at most one flag is raised.
- R10: With OUT_STAGE=1 the outputs show the decision for the inputs sampled at the previous rising clock edge. A synchronous active-high reset drives every output to 0. With OUT_STAGE=0 the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_cls | input | 2 | Dividend class code |
| a_snan | input | 1 | Dividend signalling bit, meaningful only for NaN |
| a_sign | input | 1 | Dividend sign |
| b_cls | input | 2 | Divisor class code |
| b_snan | input | 1 | Divisor signalling bit, meaningful only for NaN |
| b_sign | input | 1 | Divisor sign |
| path_oh | output | 5 | One-hot result path; bit 4 requests the divider |
| res_cls | output | 2 | Result class code |
| res_sign | output | 1 | Result sign |
| flg_snan | output | 1 | Invalid: signalling NaN operand |
| flg_inf_inf | output | 1 | Invalid: infinity divided by infinity |
| flg_zero_zero | output | 1 | Invalid: zero divided by zero |
| flg_div_zero | output | 1 | Divide by zero |

## Verification
The bench builds two copies of the block, one with OUT_STAGE=1 and one with OUT_STAGE=0, and drives both with the same operands. The combinational copy shows the decision table directly. The registered copy adds the one-cycle latency, the held value while the inputs change between edges, and the reset-to-zero behaviour. Every class pair is combined with all four sign pairs and all four signalling-bit pairs. This covers the NaN arbitration corners and shows that a signalling bit on a non-NaN operand is ignored.

// File: rtl/fdsc_pkg.sv
package fdsc_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'b00,
        CLS_NORM = 2'b01,
        CLS_INF  = 2'b10,
        CLS_NAN  = 2'b11
    } fcls_e;

    localparam int PATH_N  = 5;
    localparam int P_FWD_A = 0;
    localparam int P_FWD_B = 1;
    localparam int P_DNAN  = 2;
    localparam int P_CONST = 3;
    localparam int P_DIV   = 4;

    typedef struct packed {
        fcls_e cls;
        logic  snan;
        logic  sign;
    } opnd_t;

    typedef struct packed {
        logic [PATH_N-1:0] path;
        fcls_e             cls;
        logic              sign;
        logic              f_snan;
        logic              f_ii;
        logic              f_zz;
        logic              f_dz;
    } verdict_t;

    function automatic logic is_nan(opnd_t o);
        return o.cls == CLS_NAN;
    endfunction

    function automatic logic is_sig(opnd_t o);
        return (o.cls == CLS_NAN) && o.snan;
    endfunction

endpackage

// File: rtl/fdsc_nan_pick.sv
module fdsc_nan_pick
    import fdsc_pkg::*;
(
    input  opnd_t op_a,
    input  opnd_t op_b,
    output logic  any_nan,
    output logic  pick_b,
    output logic  sig_seen
);
    logic a_nan, b_nan, a_sig, b_sig;

    always_comb begin
        a_nan    = is_nan(op_a);
        b_nan    = is_nan(op_b);
        a_sig    = is_sig(op_a);
        b_sig    = is_sig(op_b);
        any_nan  = a_nan | b_nan;
        // divisor wins only if it is the sole NaN or the sole signalling NaN
        pick_b   = b_nan && (!a_nan || (b_sig && !a_sig));
        sig_seen = a_sig | b_sig;
    end
endmodule

// File: rtl/fdsc_case_table.sv
module fdsc_case_table
    import fdsc_pkg::*;
(
    input  opnd_t    op_a,
    input  opnd_t    op_b,
    input  logic     any_nan,
    input  logic     pick_b,
    input  logic     sig_seen,
    output verdict_t vd
);
    logic sgn_x;
    assign sgn_x = op_a.sign ^ op_b.sign;

    always_comb begin
        vd = '0;
        if (any_nan) begin
            vd.path[pick_b ? P_FWD_B : P_FWD_A] = 1'b1;
            vd.cls    = CLS_NAN;
            vd.sign   = pick_b ? op_b.sign : op_a.sign;
            vd.f_snan = sig_seen;
        end else begin
            unique case (op_a.cls)
                CLS_ZERO: begin
                    if (op_b.cls == CLS_ZERO) begin
                        vd.path[P_DNAN] = 1'b1;
                        vd.cls          = CLS_NAN;
                        vd.f_zz         = 1'b1;
                    end else begin
                        vd.path[P_FWD_A] = 1'b1;
                        vd.cls           = CLS_ZERO;
                        vd.sign          = op_a.sign;
                    end
                end
                CLS_INF: begin
                    if (op_b.cls == CLS_INF) begin
                        vd.path[P_DNAN] = 1'b1;
                        vd.cls          = CLS_NAN;
                        vd.f_ii         = 1'b1;
                    end else begin
                        vd.path[P_FWD_A] = 1'b1;
                        vd.cls           = CLS_INF;
                        vd.sign          = op_a.sign;
                    end
                end
                CLS_NORM: begin
                    vd.sign = sgn_x;
                    unique case (op_b.cls)
                        CLS_ZERO: begin
                            vd.path[P_CONST] = 1'b1;
                            vd.cls           = CLS_INF;
                            vd.f_dz          = 1'b1;
                        end
                        CLS_INF: begin
                            vd.path[P_CONST] = 1'b1;
                            vd.cls           = CLS_ZERO;
                        end
                        default: begin
                            vd.path[P_DIV] = 1'b1;
                            vd.cls         = CLS_NORM;
                        end
                    endcase
                end
                default: vd = '0;
            endcase
        end
    end
endmodule

// File: rtl/fdsc_out_reg.sv
module fdsc_out_reg
    import fdsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  verdict_t d,
    output verdict_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/fdsc_resolver.sv
module fdsc_resolver
    import fdsc_pkg::*;
#(
    parameter bit OUT_STAGE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           a_cls,
    input  logic                 a_snan,
    input  logic                 a_sign,
    input  logic [1:0]           b_cls,
    input  logic                 b_snan,
    input  logic                 b_sign,
    output logic [PATH_N-1:0]    path_oh,
    output logic [1:0]           res_cls,
    output logic                 res_sign,
    output logic                 flg_snan,
    output logic                 flg_inf_inf,
    output logic                 flg_zero_zero,
    output logic                 flg_div_zero
);
    opnd_t    op_a, op_b;
    verdict_t v_nxt, v_out;
    logic     any_nan, pick_b, sig_seen;

    assign op_a = '{cls: fcls_e'(a_cls), snan: a_snan, sign: a_sign};
    assign op_b = '{cls: fcls_e'(b_cls), snan: b_snan, sign: b_sign};

    fdsc_nan_pick u_nan (
        .op_a    (op_a),
        .op_b    (op_b),
        .any_nan (any_nan),
        .pick_b  (pick_b),
        .sig_seen(sig_seen)
    );

    fdsc_case_table u_tbl (
        .op_a    (op_a),
        .op_b    (op_b),
        .any_nan (any_nan),
        .pick_b  (pick_b),
        .sig_seen(sig_seen),
        .vd      (v_nxt)
    );

    generate
        if (OUT_STAGE) begin : g_reg
            fdsc_out_reg u_oreg (
                .clk(clk),
                .rst(rst),
                .d  (v_nxt),
                .q  (v_out)
            );
            p_latency_r10: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> v_out == $past(v_nxt));
        end else begin : g_comb
            assign v_out = v_nxt;
        end
    endgenerate

    assign path_oh       = v_out.path;
    assign res_cls       = v_out.cls;
    assign res_sign      = v_out.sign;
    assign flg_snan      = v_out.f_snan;
    assign flg_inf_inf   = v_out.f_ii;
    assign flg_zero_zero = v_out.f_zz;
    assign flg_div_zero  = v_out.f_dz;

    p_one_path_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot(v_nxt.path));
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({v_nxt.f_snan, v_nxt.f_ii, v_nxt.f_zz, v_nxt.f_dz}));
    p_dz_cause_r7: assert property (@(posedge clk) disable iff (rst)
        v_nxt.f_dz |-> (a_cls == 2'b01 && b_cls == 2'b00));
    p_div_req_r8: assert property (@(posedge clk) disable iff (rst)
        v_nxt.path[P_DIV] |-> (a_cls == 2'b01 && b_cls == 2'b01
                               && v_nxt.sign == (a_sign ^ b_sign)));
    p_nan_fwd_r1: assert property (@(posedge clk) disable iff (rst)
        (a_cls == 2'b11 || b_cls == 2'b11) |->
            (v_nxt.cls == CLS_NAN && (v_nxt.path[P_FWD_A] || v_nxt.path[P_FWD_B])));
    p_sig_flag_r2: assert property (@(posedge clk) disable iff (rst)
        v_nxt.f_snan |-> ((a_cls == 2'b11 && a_snan) || (b_cls == 2'b11 && b_snan)));
endmodule

// File: tb/fdsc_resolver_bench.sv
module fdsc_resolver_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] a_cls = 2'b01, b_cls = 2'b01;
    logic a_snan = 1'b0, a_sign = 1'b0, b_snan = 1'b0, b_sign = 1'b0;

    logic [4:0] r_path, c_path;
    logic [1:0] r_cls, c_cls;
    logic r_sign, r_sn, r_ii, r_zz, r_dz;
    logic c_sign, c_sn, c_ii, c_zz, c_dz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fdsc_resolver #(.OUT_STAGE(1'b1)) u_fdsc_resolver (
        .clk(clk), .rst(rst), .a_cls(a_cls), .a_snan(a_snan), .a_sign(a_sign),
        .b_cls(b_cls), .b_snan(b_snan), .b_sign(b_sign),
        .path_oh(r_path), .res_cls(r_cls), .res_sign(r_sign), .flg_snan(r_sn),
        .flg_inf_inf(r_ii), .flg_zero_zero(r_zz), .flg_div_zero(r_dz));

    fdsc_resolver #(.OUT_STAGE(1'b0)) u_fdsc_resolver_comb (
        .clk(clk), .rst(rst), .a_cls(a_cls), .a_snan(a_snan), .a_sign(a_sign),
        .b_cls(b_cls), .b_snan(b_snan), .b_sign(b_sign),
        .path_oh(c_path), .res_cls(c_cls), .res_sign(c_sign), .flg_snan(c_sn),
        .flg_inf_inf(c_ii), .flg_zero_zero(c_zz), .flg_div_zero(c_dz));

    // index = {a_cls, b_cls}; fields: [12:8] path, [7:6] class,
    // [5:4] sign rule (0 dividend, 1 xor, 2 zero, 3 NaN pick), [3:0] {snan,ii,zz,dz}
    localparam logic [12:0] TBL [16] = '{
        {5'b00100, 2'b11, 2'd2, 4'b0010},
        {5'b00001, 2'b00, 2'd0, 4'b0000},
        {5'b00001, 2'b00, 2'd0, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b01000, 2'b10, 2'd1, 4'b0001},
        {5'b10000, 2'b01, 2'd1, 4'b0000},
        {5'b01000, 2'b00, 2'd1, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b00001, 2'b10, 2'd0, 4'b0000},
        {5'b00001, 2'b10, 2'd0, 4'b0000},
        {5'b00100, 2'b11, 2'd2, 4'b0100},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000},
        {5'b00000, 2'b11, 2'd3, 4'b0000}
    };

    function automatic string tag_of(int idx);
        case (idx)
            0:       return "R4";
            1, 2:    return "R6";
            4, 6:    return "R7";
            5:       return "R8";
            8, 9:    return "R5";
            10:      return "R3";
            default: return "R1";
        endcase
    endfunction

    // expected {path5, cls2, sign, snan, ii, zz, dz}
    function automatic logic [11:0] expect_of(logic [1:0] ac, logic [1:0] bc,
                                              logic asn, logic bsn, logic sa, logic sb);
        logic [12:0] e;
        logic an, bn, asig, bsig, pb, s;
        e = TBL[{ac, bc}];
        if (e[5:4] == 2'd3) begin
            an = (ac == 2'b11); bn = (bc == 2'b11);
            asig = an & asn;    bsig = bn & bsn;
            pb = bn && (!an || (bsig && !asig));
            return {(pb ? 5'b00010 : 5'b00001), 2'b11, (pb ? sb : sa),
                    (asig | bsig), 3'b000};
        end
        case (e[5:4])
            2'd0:    s = sa;
            2'd1:    s = sa ^ sb;
            default: s = 1'b0;
        endcase
        return {e[12:8], e[7:6], s, e[3:0]};
    endfunction

    function automatic logic [11:0] reg_vec();
        return {r_path, r_cls, r_sign, r_sn, r_ii, r_zz, r_dz};
    endfunction

    function automatic logic [11:0] comb_vec();
        return {c_path, c_cls, c_sign, c_sn, c_ii, c_zz, c_dz};
    endfunction

    task automatic chk(string tag, string what, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] ac, logic [1:0] bc, logic asn, logic bsn,
                         logic sa, logic sb);
        a_cls = ac; b_cls = bc; a_snan = asn; b_snan = bsn; a_sign = sa; b_sign = sb;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] e_div;
        e_div = expect_of(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        // reset state of the registered copy (R10)
        repeat (3) @(negedge clk);
        chk("R10", "reset outputs", reg_vec(), 12'h000);
        chk("R8", "comb normal/normal during reset", comb_vec(), e_div);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "first registered after reset", reg_vec(), e_div);

        // sweep every class pair, sign pair and signalling-bit pair
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 4; s++) begin
                for (int n = 0; n < 4; n++) begin
                    logic [1:0] ac, bc;
                    logic [11:0] ex;
                    string tg;
                    ac = 2'(i >> 2); bc = 2'(i & 3);
                    drive(ac, bc, n[1], n[0], s[1], s[0]);
                    ex = expect_of(ac, bc, n[1], n[0], s[1], s[0]);
                    tg = tag_of(i);
                    if (n != 0 && TBL[i][5:4] != 2'd3) tg = "R2";
                    else if (TBL[i][5:4] == 2'd3 && ex[3]) tg = "R2";
                    #1;
                    chk(tg, "combinational", comb_vec(), ex);
                    chk("R9", "one-hot path", 12'($countones(c_path)), 12'd1);
                    @(negedge clk);
                    chk(tg, "registered", reg_vec(), ex);
                end
            end
        end

        // both NaN, equal signalling bits: dividend is kept (R1)
        drive(2'b11, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        #1;
        chk("R1", "both signalling NaN", comb_vec(), {5'b00001, 2'b11, 1'b0, 4'b1000});
        // only divisor signalling: divisor is forwarded (R1)
        drive(2'b11, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
        #1;
        chk("R1", "signalling divisor wins", comb_vec(), {5'b00010, 2'b11, 1'b1, 4'b1000});

        // registered copy holds between edges (R10)
        @(negedge clk);
        drive(2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        drive(2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1);
        #1;
        chk("R10", "registered holds old decision", reg_vec(),
            {5'b01000, 2'b10, 1'b1, 4'b0001});
        chk("R3", "comb inf/inf", comb_vec(), {5'b00100, 2'b11, 1'b0, 4'b0100});

        // reset in the middle of operation (R10)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10", "mid-run reset", reg_vec(), 12'h000);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "after mid-run reset", reg_vec(), {5'b00100, 2'b11, 1'b0, 4'b0100});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule